// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block sits between the point where stores commit and the data cache. A committed store is handed over with a cache-line address, a full line of data and a per-byte enable mask. The buffer takes it in the cycle it is offered, provided it has room, and from then on the store counts as done for the core, whether or not the cache could take it yet. Several stores to one line collapse into one entry, so a single line write to the cache carries all of them. The block sets aside a separate entry for stores flagged as not combinable.

Entries leave in the order they were created. The oldest live entry is always offered on a valid/ready write port toward the cache. While it is being offered, no further store may merge into it. A load can probe the buffer with a line address at any time. It receives, for each byte, the value from the youngest entry that covers it, together with a per-byte hit mask. The caller fills any byte that has no hit from the cache.

Top module: `wcb_top`

## Requirements
- R1: After reset the write port is idle (wrValid low), stReady is high and a load probe reports no hit bytes (ldHit all zero).
- R2: A store is taken when stValid and stReady are both high at a clock edge. Stores that do not merge create entries in arrival order, and the write port offers the entries oldest first.
- R3: A combinable store whose line address matches the youngest live entry for that line merges into that entry, provided the entry is combinable and not being drained. Each byte b with stMask[b] set takes stData[8b+7:8b], the entry mask becomes the OR of both masks, and one line write later carries every merged store.
- R4: Forwarding is combinational. For each byte b of ldAddr's line, ldHit[b] is set when some live entry holds that byte. ldData[8b+7:8b] is then the value from the youngest such entry. Bytes with no hit read as zero.
- R5: The oldest live entry is offered on the write port and is locked. A store to its line opens a new entry. While wrValid is high and wrReady is low, wrAddr, wrData and wrMask hold their values.
- R6: When all DEPTH entries are live, stReady is low for a store that cannot merge, and such a store leaves no trace. A store that can merge is still taken while the buffer is full.
- R7: A store with stNoComb high always opens its own entry, and no later store merges into that entry.
- R8: A write handshake (wrValid and wrReady high) frees the offered entry, and the next oldest entry is offered in the following cycle. A store may open an entry in that same cycle.
- R9: A store taken at a clock edge becomes visible to load probes only after that edge, not in the cycle it is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 1 | Committed store offered |
| stReady | output | 1 | Store taken this cycle |
| stAddr | input | LINE_ADDR_W | Line address of the store |
| stData | input | LINE_BYTES*8 | Line-wide store data, byte b at bits 8b+7:8b |
| stMask | input | LINE_BYTES | Byte enables of the store |
| stNoComb | input | 1 | Store must not combine |
| ldAddr | input | LINE_ADDR_W | Line address of a load probe |
| ldData | output | LINE_BYTES*8 | Forwarded bytes |
| ldHit | output | LINE_BYTES | Per-byte forward hit mask |
| wrValid | output | 1 | Line write to the cache offered |
| wrReady | input | 1 | Cache takes the line write |
| wrAddr | output | LINE_ADDR_W | Line address of the write |
| wrData | output | LINE_BYTES*8 | Line data of the write |
| wrMask | output | LINE_BYTES | Valid bytes of the write |

## Verification
Two pairs of events can fall on the same edge. A write handshake can retire the oldest entry while a new store opens a slot. A load can also probe a line that a store is being written into. The bench raises wrReady and stValid in the same cycle and probes the store's line before that edge and after it. It expects no hit before the edge, and after the edge the new store's bytes as the only offered entry. A second case checks that a store to the line being drained opens a new entry rather than changing the data on the write port.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
  // Strobes from the control to the datapath for one clock edge.
  typedef struct packed {
    logic alloc;  // open a fresh entry at the target slot
    logic merge;  // fold the store into the target slot
    logic pop;    // the oldest slot leaves toward the cache
  } wcbStrobe_t;
endpackage

// File: rtl/wcb_ctrl.sv
module wcb_ctrl import wcb_pkg::*; #(
  parameter int DEPTH = 4,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stValid,
  input  logic             stNoComb,
  input  logic [DEPTH-1:0] matchVec,
  input  logic             wrReady,
  output logic             stReady,
  output wcbStrobe_t       strb,
  output logic [IW-1:0]    tgtIdx,
  output logic [IW-1:0]    headIdx,
  output logic [DEPTH-1:0] liveVec,
  output logic             wrValid
);
  // DEPTH must be a power of two; ring pointers wrap naturally.
  localparam logic [IW:0] FULL_CNT = (IW+1)'(DEPTH);

  logic [DEPTH-1:0] liveQ;
  logic [DEPTH-1:0] soloQ;
  logic [IW-1:0]    headQ;
  logic [IW-1:0]    tailQ;
  logic [IW:0]      countQ;

  logic             youngFound;
  logic [IW-1:0]    youngIdx;
  logic             canMerge;
  logic             full;
  logic             fire;

  // Walk slots from oldest to youngest; the last match is the youngest.
  always_comb begin
    youngFound = 1'b0;
    youngIdx   = headQ;
    for (int k = 0; k < DEPTH; k++) begin
      automatic logic [IW-1:0] pos = headQ + IW'(k);
      if (liveQ[pos] && matchVec[pos]) begin
        youngFound = 1'b1;
        youngIdx   = pos;
      end
    end
  end

  // The oldest slot is locked while offered to the cache.
  assign canMerge = youngFound && !stNoComb && !soloQ[youngIdx] && (youngIdx != headQ);
  assign full     = (countQ == FULL_CNT);
  assign stReady  = canMerge || !full;
  assign fire     = stValid && stReady;

  assign wrValid    = liveQ[headQ];
  assign strb.merge = fire && canMerge;
  assign strb.alloc = fire && !canMerge;
  assign strb.pop   = wrValid && wrReady;
  assign tgtIdx     = canMerge ? youngIdx : tailQ;
  assign headIdx    = headQ;
  assign liveVec    = liveQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveQ  <= '0;
      soloQ  <= '0;
      headQ  <= '0;
      tailQ  <= '0;
      countQ <= '0;
    end else begin
      if (strb.alloc) begin
        liveQ[tailQ] <= 1'b1;
        soloQ[tailQ] <= stNoComb;
        tailQ        <= tailQ + IW'(1);
      end
      if (strb.pop) begin
        liveQ[headQ] <= 1'b0;
        headQ        <= headQ + IW'(1);
      end
      case ({strb.alloc, strb.pop})
        2'b10:   countQ <= countQ + (IW+1)'(1);
        2'b01:   countQ <= countQ - (IW+1)'(1);
        default: countQ <= countQ;
      endcase
    end
  end

  // R6: stall happens only with every slot occupied.
  a_r6_stall_only_full: assert property (@(posedge clk) disable iff (!rstN)
    !stReady |-> countQ == FULL_CNT);

  // R8: occupancy counter agrees with the live flags.
  a_r8_live_count: assert property (@(posedge clk) disable iff (!rstN)
    $countones(liveQ) == int'(countQ));
endmodule

// File: rtl/wcb_data.sv
module wcb_data import wcb_pkg::*; #(
  parameter int DEPTH       = 4,
  parameter int LINE_ADDR_W = 26,
  parameter int LINE_BYTES  = 64,
  localparam int IW = $clog2(DEPTH),
  localparam int DW = LINE_BYTES * 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  wcbStrobe_t             strb,
  input  logic [IW-1:0]          tgtIdx,
  input  logic [IW-1:0]          headIdx,
  input  logic [DEPTH-1:0]       liveVec,
  input  logic [LINE_ADDR_W-1:0] stAddr,
  input  logic [DW-1:0]          stData,
  input  logic [LINE_BYTES-1:0]  stMask,
  input  logic [LINE_ADDR_W-1:0] ldAddr,
  output logic [DEPTH-1:0]       matchVec,
  output logic [LINE_ADDR_W-1:0] wrAddr,
  output logic [DW-1:0]          wrData,
  output logic [LINE_BYTES-1:0]  wrMask,
  output logic [DW-1:0]          ldData,
  output logic [LINE_BYTES-1:0]  ldHit
);
  logic [LINE_ADDR_W-1:0]      lineAddr [DEPTH];
  logic [LINE_BYTES-1:0][7:0]  lineData [DEPTH];
  logic [LINE_BYTES-1:0]       byteMask [DEPTH];
  logic [LINE_BYTES-1:0][7:0]  stBytes;
  logic [LINE_BYTES-1:0][7:0]  fwdBytes;

  assign stBytes = stData;

  always_ff @(posedge clk) begin
    if (strb.alloc) begin
      lineAddr[tgtIdx] <= stAddr;
      byteMask[tgtIdx] <= stMask;
      for (int b = 0; b < LINE_BYTES; b++)
        lineData[tgtIdx][b] <= stMask[b] ? stBytes[b] : 8'h00;
    end else if (strb.merge) begin
      byteMask[tgtIdx] <= byteMask[tgtIdx] | stMask;
      for (int b = 0; b < LINE_BYTES; b++)
        if (stMask[b]) lineData[tgtIdx][b] <= stBytes[b];
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : gMatch
    assign matchVec[i] = (lineAddr[i] == stAddr);
  end

  assign wrAddr = lineAddr[headIdx];
  assign wrData = lineData[headIdx];
  assign wrMask = byteMask[headIdx];

  // Oldest to youngest, so younger bytes overwrite older ones.
  always_comb begin
    fwdBytes = '0;
    ldHit    = '0;
    for (int k = 0; k < DEPTH; k++) begin
      automatic logic [IW-1:0] pos = headIdx + IW'(k);
      if (liveVec[pos] && (lineAddr[pos] == ldAddr)) begin
        for (int b = 0; b < LINE_BYTES; b++) begin
          if (byteMask[pos][b]) begin
            fwdBytes[b] = lineData[pos][b];
            ldHit[b]    = 1'b1;
          end
        end
      end
    end
  end
  assign ldData = fwdBytes;

  // R3: every enabled byte of a written store is held afterwards.
  a_r3_merge_sets_bytes: assert property (@(posedge clk) disable iff (!rstN)
    (strb.alloc || strb.merge) |=>
      ((byteMask[$past(tgtIdx)] & $past(stMask)) == $past(stMask)));

  // R4: nothing is forwarded from an empty buffer.
  a_r4_no_phantom_hit: assert property (@(posedge clk) disable iff (!rstN)
    (liveVec == '0) |-> (ldHit == '0));
endmodule

// File: rtl/wcb_top.sv
module wcb_top import wcb_pkg::*; #(
  parameter int DEPTH       = 4,
  parameter int LINE_ADDR_W = 26,
  parameter int LINE_BYTES  = 64,
  localparam int IW = $clog2(DEPTH),
  localparam int DW = LINE_BYTES * 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   stValid,
  output logic                   stReady,
  input  logic [LINE_ADDR_W-1:0] stAddr,
  input  logic [DW-1:0]          stData,
  input  logic [LINE_BYTES-1:0]  stMask,
  input  logic                   stNoComb,
  input  logic [LINE_ADDR_W-1:0] ldAddr,
  output logic [DW-1:0]          ldData,
  output logic [LINE_BYTES-1:0]  ldHit,
  output logic                   wrValid,
  input  logic                   wrReady,
  output logic [LINE_ADDR_W-1:0] wrAddr,
  output logic [DW-1:0]          wrData,
  output logic [LINE_BYTES-1:0]  wrMask
);
  wcbStrobe_t       strb;
  logic [IW-1:0]    tgtIdx;
  logic [IW-1:0]    headIdx;
  logic [DEPTH-1:0] liveVec;
  logic [DEPTH-1:0] matchVec;

  wcb_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stNoComb(stNoComb),
    .matchVec(matchVec), .wrReady(wrReady), .stReady(stReady),
    .strb(strb), .tgtIdx(tgtIdx), .headIdx(headIdx),
    .liveVec(liveVec), .wrValid(wrValid)
  );

  wcb_data #(.DEPTH(DEPTH), .LINE_ADDR_W(LINE_ADDR_W), .LINE_BYTES(LINE_BYTES)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .tgtIdx(tgtIdx), .headIdx(headIdx),
    .liveVec(liveVec), .stAddr(stAddr), .stData(stData), .stMask(stMask),
    .ldAddr(ldAddr), .matchVec(matchVec), .wrAddr(wrAddr), .wrData(wrData),
    .wrMask(wrMask), .ldData(ldData), .ldHit(ldHit)
  );

  // R5: an offered line write holds still until the cache takes it.
  a_r5_drain_stable: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=>
      (wrValid && $stable(wrAddr) && $stable(wrData) && $stable(wrMask)));
endmodule

// File: tb/sim_wcb_top.sv
module sim_wcb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         stValid = 1'b0;
  logic         stReady;
  logic [25:0]  stAddr = '0;
  logic [511:0] stData = '0;
  logic [63:0]  stMask = '0;
  logic         stNoComb = 1'b0;
  logic [25:0]  ldAddr = '0;
  logic [511:0] ldData;
  logic [63:0]  ldHit;
  logic         wrValid;
  logic         wrReady = 1'b0;
  logic [25:0]  wrAddr;
  logic [511:0] wrData;
  logic [63:0]  wrMask;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  wcb_top u0 (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady),
    .stAddr(stAddr), .stData(stData), .stMask(stMask), .stNoComb(stNoComb),
    .ldAddr(ldAddr), .ldData(ldData), .ldHit(ldHit), .wrValid(wrValid),
    .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData), .wrMask(wrMask)
  );

  function automatic logic [511:0] pat(input logic [7:0] s);
    logic [511:0] r;
    for (int b = 0; b < 64; b++) r[b*8 +: 8] = s + 8'(b);
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at a falling edge.
  task automatic putStore(input logic [25:0] a, input logic [7:0] seed,
                          input logic [63:0] m, input logic nc,
                          input logic expAcc, input string req);
    stValid = 1'b1; stAddr = a; stData = pat(seed); stMask = m; stNoComb = nc;
    #1 chk(req, 64'(stReady), 64'(expAcc));
    @(negedge clk);
    stValid = 1'b0; stNoComb = 1'b0;
  endtask

  task automatic popOne(input logic [25:0] a, input logic [63:0] m,
                        input int b, input logic [7:0] v, input string req);
    #1;
    chk(req, 64'(wrValid), 64'd1);
    chk(req, 64'(wrAddr), 64'(a));
    chk(req, wrMask, m);
    chk(req, 64'(wrData[b*8 +: 8]), 64'(v));
    wrReady = 1'b1;
    @(negedge clk);
    wrReady = 1'b0;
  endtask

  task automatic probe(input logic [25:0] a, input logic [63:0] h,
                       input int b, input logic [7:0] v, input string req);
    ldAddr = a;
    #1;
    chk(req, ldHit, h);
    chk(req, 64'(ldData[b*8 +: 8]), 64'(v));
  endtask

  task automatic testReset();
    #1;
    chk("R1 wrValid", 64'(wrValid), 64'd0);
    chk("R1 stReady", 64'(stReady), 64'd1);
    ldAddr = 26'h10; #1;
    chk("R1 ldHit", ldHit, 64'd0);
  endtask

  task automatic testMergeAndOrder();
    putStore(26'h10, 8'h10, 64'hFF, 0, 1, "R2 store A");
    putStore(26'h20, 8'h20, 64'h0F, 0, 1, "R2 store B");
    putStore(26'h20, 8'h40, 64'h3C, 0, 1, "R3 merge B");
    putStore(26'h30, 8'h30, 64'h01, 0, 1, "R2 store C");
    #1 chk("R2 oldest offered", 64'(wrAddr), 64'h10);
    probe(26'h20, 64'h3F, 1, 8'h21, "R3 merged older byte");
    probe(26'h20, 64'h3F, 2, 8'h42, "R3 merged newer byte");
    putStore(26'h10, 8'h80, 64'h01, 0, 1, "R5 store to draining line");
    probe(26'h10, 64'hFF, 0, 8'h80, "R4 youngest byte wins");
    probe(26'h10, 64'hFF, 1, 8'h11, "R4 older byte kept");
    chk("R5 drain data locked", 64'(wrData[7:0]), 64'h10);
    putStore(26'h50, 8'h50, 64'h01, 0, 0, "R6 full stall");
    putStore(26'h20, 8'h60, 64'h40, 0, 1, "R6 merge while full");
    probe(26'h50, 64'h0, 0, 8'h00, "R6 stalled store left no trace");
    popOne(26'h10, 64'hFF, 0, 8'h10, "R5 first line write");
    probe(26'h10, 64'h01, 0, 8'h80, "R4 young entry remains");
    popOne(26'h20, 64'h7F, 6, 8'h66, "R3 one write for three stores");
    popOne(26'h30, 64'h01, 0, 8'h30, "R2 third line write");
    popOne(26'h10, 64'h01, 0, 8'h80, "R5 separate entry drained");
    #1 chk("R8 empty after drain", 64'(wrValid), 64'd0);
  endtask

  task automatic testNoCombine();
    putStore(26'h70, 8'h00, 64'hFF, 0, 1, "R7 head store");
    putStore(26'h71, 8'h10, 64'h01, 1, 1, "R7 solo store");
    putStore(26'h71, 8'h20, 64'h02, 0, 1, "R7 store after solo");
    putStore(26'h71, 8'h30, 64'h04, 0, 1, "R3 merge into normal entry");
    probe(26'h71, 64'h07, 2, 8'h32, "R7 forward across entries");
    putStore(26'h71, 8'h40, 64'h01, 1, 1, "R7 second solo store");
    probe(26'h71, 64'h07, 0, 8'h40, "R4 solo youngest byte");
    popOne(26'h70, 64'hFF, 0, 8'h00, "R7 drain head");
    popOne(26'h71, 64'h01, 0, 8'h10, "R7 solo kept alone");
    popOne(26'h71, 64'h06, 2, 8'h32, "R7 normal entry merged");
    popOne(26'h71, 64'h01, 0, 8'h40, "R7 second solo alone");
  endtask

  task automatic testSameCycle();
    putStore(26'hA0, 8'h00, 64'h01, 0, 1, "R8 seed entry");
    stValid = 1'b1; stAddr = 26'hB0; stData = pat(8'h50); stMask = 64'h03;
    wrReady = 1'b1; ldAddr = 26'hB0;
    #1;
    chk("R9 not visible before edge", ldHit, 64'h0);
    chk("R8 store taken with drain", 64'(stReady), 64'd1);
    chk("R8 drained line", 64'(wrAddr), 64'hA0);
    @(negedge clk);
    stValid = 1'b0; wrReady = 1'b0;
    #1;
    chk("R8 next entry offered", 64'(wrAddr), 64'hB0);
    chk("R9 visible after edge", ldHit, 64'h03);
    popOne(26'hB0, 64'h03, 1, 8'h51, "R8 drain new entry");
    #1 chk("R8 idle", 64'(wrValid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMergeAndOrder();
    testNoCombine();
    testSameCycle();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule